// File: doc/BRIEF.md
# DRAM Bank Row/Column Sequencer

This block turns single read or write requests into the command sequence a banked DRAM array needs. Each request names a bank, a row, a column and a direction. The block keeps a table with one open-row entry per bank. It then picks one of three paths:

- **Row hit.** The bank already has this row open, so the block issues only a column command.
- **Closed bank.** No row is open, so the block activates the row first.
- **Row conflict.** A different row is open, so the block closes it with a precharge, activates the new row, and then issues the column command.

Row and column addresses share one address bus and go out in different cycles. Each command phase waits for its own latency, which is set by a parameter in cycles, before the next command may go out.

Requests use a valid/ready handshake and are served one at a time. While a sequence is in flight, ready stays low. Read data comes from the device's data pins once the column latency has run out. The block returns it with a one-cycle valid strobe. Write data goes out together with the write command.

Top module: `dram_row_seq`

## Requirements
- R1: Reset is synchronous and active high. After reset, `req_ready` is 1, `rsp_valid` is 0, `dram_cmd` is NOP and every bank is closed, so the next access to any bank starts with an activate.
- R2: A request to a bank whose open row equals the requested row produces exactly one command, the column command, in the cycle after acceptance.
- R3: A request to a bank that holds a different open row produces exactly precharge, then activate, then column. The first comes in the cycle after acceptance. An activate never targets a bank that is open, and a precharge never targets a bank that is closed.
- R4: A request to a closed bank produces exactly activate, then column, with no precharge.
- R5: A precharge is followed by the activate `PRE_CYC` cycles later. An activate is followed by the column command `ACT_CYC` cycles later. All cycles between commands show NOP.
- R6: `req_ready` goes low in the cycle after acceptance and comes back high `COL_CYC` cycles after the column command. Requests presented while it is low have no effect on the commands, the addresses or the stored data.
- R7: A read raises `rsp_valid` for exactly one cycle, `COL_CYC` cycles after the read command. `rsp_data` carries the value on `dram_rdata` in the cycle before that.
- R8: A write drives the request data on `dram_wdata` while the write command is shown, and it never raises `rsp_valid`.
- R9: Every command carries the request's bank on `dram_bank`. An activate carries the row on `dram_addr`, and a column command carries the column there, zero-extended.
- R10: The command codes on `dram_cmd` are NOP=0, ACT=1, RD=2, WR=3, PRE=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and taking a request |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data strobe |
| rsp_data | output | DATA_W | Read data |
| dram_cmd | output | 3 | Command code (R10) |
| dram_bank | output | BANK_W | Bank of the command |
| dram_addr | output | ADDR_W | Row or column address |
| dram_wdata | output | DATA_W | Data for a write command |
| dram_rdata | input | DATA_W | Data returned by the device |

## Verification
The hardest case to reach is a row conflict, because it only appears after an earlier request has left a different row open in the same bank. The stimulus table therefore chains requests so that each bank is first opened, then hit, then redirected to another row and back again. Data written before the redirection is read back afterwards. A second hard case is reset arriving in the middle of a sequence, with a precharge already issued. A directed test drops reset into that window and then checks that a former hit now starts with an activate.

// File: rtl/drs_pkg.sv
package drs_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } drs_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRE,
        ST_ACT,
        ST_COL
    } drs_state_e;

    typedef enum logic [1:0] {
        PATH_HIT,
        PATH_CLOSED,
        PATH_MISS
    } drs_path_e;

    function automatic drs_path_e drs_classify(input logic is_open, input logic same_row);
        if (!is_open)
            return PATH_CLOSED;
        if (same_row)
            return PATH_HIT;
        return PATH_MISS;
    endfunction

    function automatic drs_cmd_e drs_col_cmd(input logic is_write);
        return is_write ? CMD_WR : CMD_RD;
    endfunction

endpackage

// File: rtl/drs_phase_timer.sv
module drs_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // A non-zero phase length keeps the phase busy in the next cycle (R5).
    p_phase_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (load && load_val != '0) |=> !zero);

endmodule

// File: rtl/drs_bank_table.sv
module drs_bank_table #(
    parameter int BANKS  = 4,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              open_en,
    input  logic [BANK_W-1:0] open_bank,
    input  logic [ROW_W-1:0]  open_row,
    input  logic              close_en,
    input  logic [BANK_W-1:0] close_bank,
    input  logic [BANK_W-1:0] look_bank,
    output logic              look_open,
    output logic [ROW_W-1:0]  look_row
);

    logic [BANKS-1:0] is_open;
    logic [ROW_W-1:0] row_tab [BANKS];

    generate
        for (genvar g = 0; g < BANKS; g++) begin : g_bank
            logic             open_q;
            logic [ROW_W-1:0] row_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    open_q <= 1'b0;
                    row_q  <= '0;
                end else if (open_en && open_bank == BANK_W'(g)) begin
                    open_q <= 1'b1;
                    row_q  <= open_row;
                end else if (close_en && close_bank == BANK_W'(g)) begin
                    open_q <= 1'b0;
                end
            end

            assign is_open[g] = open_q;
            assign row_tab[g] = row_q;
        end
    endgenerate

    assign look_open = is_open[look_bank];
    assign look_row  = row_tab[look_bank];

    // Activation only ever lands on a closed bank (R3).
    p_act_on_closed_r3: assert property (@(posedge clk) disable iff (rst)
        open_en |-> !is_open[open_bank]);

    // Precharge only ever closes an open bank (R3).
    p_pre_on_open_r3: assert property (@(posedge clk) disable iff (rst)
        close_en |-> is_open[close_bank]);

endmodule

// File: rtl/dram_row_seq.sv
module dram_row_seq #(
    parameter int BANKS   = 4,
    parameter int ROW_W   = 4,
    parameter int COL_W   = 3,
    parameter int DATA_W  = 8,
    parameter int PRE_CYC = 2,
    parameter int ACT_CYC = 3,
    parameter int COL_CYC = 4,
    localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [2:0]        dram_cmd,
    output logic [BANK_W-1:0] dram_bank,
    output logic [ADDR_W-1:0] dram_addr,
    output logic [DATA_W-1:0] dram_wdata,
    input  logic [DATA_W-1:0] dram_rdata
);
    import drs_pkg::*;

    localparam int MAX_LAT = (PRE_CYC > ACT_CYC) ?
                             ((PRE_CYC > COL_CYC) ? PRE_CYC : COL_CYC) :
                             ((ACT_CYC > COL_CYC) ? ACT_CYC : COL_CYC);
    localparam int CNT_W   = $clog2(MAX_LAT + 1);

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              write;
        logic [DATA_W-1:0] wdata;
    } req_t;

    drs_state_e        state_q, state_d;
    req_t              cur_q, in_req, src;
    drs_cmd_e          cmd_q, iss_cmd;
    logic              iss, done, accept;
    logic [ADDR_W-1:0] iss_addr;
    logic [CNT_W-1:0]  tval;
    logic              t_zero;
    logic              look_open;
    logic [ROW_W-1:0]  look_row;
    logic [BANK_W-1:0] look_bank;
    drs_path_e         path;
    logic [BANK_W-1:0] bank_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              rsp_v_q;
    logic [DATA_W-1:0] rsp_d_q;

    assign in_req    = '{bank: req_bank, row: req_row, col: req_col,
                         write: req_write, wdata: req_wdata};
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign src       = (state_q == ST_IDLE) ? in_req : cur_q;
    assign look_bank = src.bank;
    assign path      = drs_classify(look_open, look_row == src.row);

    always_comb begin
        state_d  = state_q;
        iss      = 1'b0;
        iss_cmd  = CMD_NOP;
        iss_addr = '0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    iss = 1'b1;
                    unique case (path)
                        PATH_HIT: begin
                            iss_cmd  = drs_col_cmd(src.write);
                            iss_addr = ADDR_W'(src.col);
                            state_d  = ST_COL;
                        end
                        PATH_CLOSED: begin
                            iss_cmd  = CMD_ACT;
                            iss_addr = ADDR_W'(src.row);
                            state_d  = ST_ACT;
                        end
                        default: begin
                            iss_cmd  = CMD_PRE;
                            state_d  = ST_PRE;
                        end
                    endcase
                end
            end
            ST_PRE: begin
                if (t_zero) begin
                    iss      = 1'b1;
                    iss_cmd  = CMD_ACT;
                    iss_addr = ADDR_W'(src.row);
                    state_d  = ST_ACT;
                end
            end
            ST_ACT: begin
                if (t_zero) begin
                    iss      = 1'b1;
                    iss_cmd  = drs_col_cmd(src.write);
                    iss_addr = ADDR_W'(src.col);
                    state_d  = ST_COL;
                end
            end
            default: begin
                if (t_zero) begin
                    done    = 1'b1;
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    always_comb begin
        unique case (iss_cmd)
            CMD_PRE: tval = CNT_W'(PRE_CYC - 1);
            CMD_ACT: tval = CNT_W'(ACT_CYC - 1);
            default: tval = CNT_W'(COL_CYC - 1);
        endcase
    end

    drs_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (iss),
        .load_val (tval),
        .zero     (t_zero)
    );

    drs_bank_table #(.BANKS(BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_table (
        .clk        (clk),
        .rst        (rst),
        .open_en    (iss && iss_cmd == CMD_ACT),
        .open_bank  (src.bank),
        .open_row   (src.row),
        .close_en   (iss && iss_cmd == CMD_PRE),
        .close_bank (src.bank),
        .look_bank  (look_bank),
        .look_open  (look_open),
        .look_row   (look_row)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            cmd_q   <= CMD_NOP;
            bank_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rsp_v_q <= 1'b0;
            rsp_d_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept)
                cur_q <= in_req;
            cmd_q <= iss ? iss_cmd : CMD_NOP;
            if (iss) begin
                bank_q <= src.bank;
                addr_q <= iss_addr;
                if (iss_cmd == CMD_WR)
                    wdata_q <= src.wdata;
            end
            rsp_v_q <= done && !cur_q.write;
            if (done && !cur_q.write)
                rsp_d_q <= dram_rdata;
        end
    end

    assign dram_cmd   = cmd_q;
    assign dram_bank  = bank_q;
    assign dram_addr  = addr_q;
    assign dram_wdata = wdata_q;
    assign rsp_valid  = rsp_v_q;
    assign rsp_data   = rsp_d_q;

    // No command goes out while the block sits idle (R6).
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> dram_cmd == 3'd0);

    // Acceptance drops ready in the following cycle (R6).
    p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // Read strobe lasts a single cycle (R7).
    p_rsp_single_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // A column command always meets the requested row open in its bank (R2).
    p_col_needs_row_r2: assert property (@(posedge clk) disable iff (rst)
        (dram_cmd == 3'd2 || dram_cmd == 3'd3) |-> (look_open && look_row == cur_q.row));

    // Writes never raise the read strobe (R8).
    p_write_silent_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !cur_q.write);

    // Activation presents the latched row on the shared address bus (R9).
    p_act_row_r9: assert property (@(posedge clk) disable iff (rst)
        dram_cmd == 3'd1 |-> dram_addr == ADDR_W'(cur_q.row));

endmodule

// File: tb/dram_row_seq_bench.sv
module dram_row_seq_bench;

    localparam int P = 2;
    localparam int A = 3;
    localparam int C = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_bank = '0;
    logic [3:0] req_row = '0;
    logic [2:0] req_col = '0;
    logic       req_write = 1'b0;
    logic [7:0] req_wdata = '0;
    logic       rsp_valid;
    logic [7:0] rsp_data;
    logic [2:0] dram_cmd;
    logic [1:0] dram_bank;
    logic [3:0] dram_addr;
    logic [7:0] dram_wdata;
    logic [7:0] dram_rdata = '0;

    dram_row_seq #(
        .BANKS(4), .ROW_W(4), .COL_W(3), .DATA_W(8),
        .PRE_CYC(P), .ACT_CYC(A), .COL_CYC(C)
    ) u_dram_row_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .dram_cmd(dram_cmd), .dram_bank(dram_bank), .dram_addr(dram_addr),
        .dram_wdata(dram_wdata), .dram_rdata(dram_rdata)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int proto_err = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Device model and command log
    logic [7:0] mem     [512];
    logic [7:0] ref_mem [512];
    logic [3:0] m_open  = '0;
    logic [3:0] m_row   [4];
    int lg_n = 0;
    int rs_n = 0;
    int rs_cyc = 0;
    logic [7:0] rs_data = '0;
    int lg_cmd [8];
    int lg_cyc [8];
    int lg_bank[8];
    int lg_addr[8];
    int lg_wd  [8];

    function automatic int idx_of(int b, int r, int c);
        return b * 128 + r * 8 + c;
    endfunction

    initial begin
        for (int i = 0; i < 512; i++) begin
            mem[i]     = 8'((i * 37 + 11) & 255);
            ref_mem[i] = 8'((i * 37 + 11) & 255);
        end
        for (int i = 0; i < 4; i++) m_row[i] = '0;
    end

    always @(negedge clk) begin
        if (rst) begin
            m_open = '0;
        end else begin
            if (dram_cmd != 3'd0) begin
                case (dram_cmd)
                    3'd1: begin
                        if (m_open[dram_bank]) proto_err++;
                        m_open[dram_bank] = 1'b1;
                        m_row[dram_bank]  = dram_addr;
                    end
                    3'd4: begin
                        if (!m_open[dram_bank]) proto_err++;
                        m_open[dram_bank] = 1'b0;
                    end
                    3'd2: begin
                        if (!m_open[dram_bank]) proto_err++;
                        dram_rdata = mem[idx_of(int'(dram_bank), int'(m_row[dram_bank]), int'(dram_addr[2:0]))];
                    end
                    3'd3: begin
                        if (!m_open[dram_bank]) proto_err++;
                        mem[idx_of(int'(dram_bank), int'(m_row[dram_bank]), int'(dram_addr[2:0]))] = dram_wdata;
                    end
                    default: proto_err++;
                endcase
                if (lg_n < 8) begin
                    lg_cmd[lg_n]  = int'(dram_cmd);
                    lg_cyc[lg_n]  = cyc;
                    lg_bank[lg_n] = int'(dram_bank);
                    lg_addr[lg_n] = int'(dram_addr);
                    lg_wd[lg_n]   = int'(dram_wdata);
                end
                lg_n++;
            end
            if (rsp_valid) begin
                rs_n++;
                rs_cyc  = cyc;
                rs_data = rsp_data;
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 20000) begin
            errors++;
            checks++;
            $display("FAIL R6 watchdog: actual=%0d expected<%0d", cyc, 20000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // kind: 0 = row hit, 1 = closed bank, 2 = row conflict
    task automatic do_req(input int kind, input logic w, input int b, input int r,
                          input int c, input logic [7:0] d);
        int k, kcol, done_c, ncmd, j;
        int ecmd [3];
        int ecyc [3];
        logic [7:0] exp_d;
        req_bank  = 2'(b);
        req_row   = 4'(r);
        req_col   = 3'(c);
        req_write = w;
        req_wdata = d;
        req_valid = 1'b1;
        while (!req_ready) begin @(negedge clk); #1; end
        lg_n = 0;
        rs_n = 0;
        k = cyc + 1;
        @(negedge clk); #1;
        // R6: noise presented while busy must be ignored
        req_bank  = 2'(b ^ 1);
        req_row   = ~4'(r);
        req_col   = ~3'(c);
        req_write = 1'b1;
        req_wdata = 8'hEE;
        while (!req_ready) begin @(negedge clk); #1; end
        req_valid = 1'b0;
        done_c = cyc;

        j = 0;
        if (kind == 2) begin ecmd[j] = 4; ecyc[j] = k; j++; end
        if (kind != 0) begin ecmd[j] = 1; ecyc[j] = k + ((kind == 2) ? P : 0); j++; end
        kcol = k + ((kind == 2) ? P : 0) + ((kind != 0) ? A : 0);
        ecmd[j] = w ? 3 : 2; ecyc[j] = kcol; j++;
        ncmd = j;

        if (kind == 0)      chk(lg_n == ncmd, "R2 hit command count", lg_n, ncmd);
        else if (kind == 1) chk(lg_n == ncmd, "R4 closed-bank command count", lg_n, ncmd);
        else                chk(lg_n == ncmd, "R3 conflict command count", lg_n, ncmd);
        for (int i = 0; i < ncmd && i < lg_n; i++) begin
            chk(lg_cmd[i] == ecmd[i], "R10 command code in sequence", lg_cmd[i], ecmd[i]);
            chk(lg_cyc[i] == ecyc[i], "R5 command cycle", lg_cyc[i] - k, ecyc[i] - k);
            chk(lg_bank[i] == b, "R9 command bank", lg_bank[i], b);
            if (ecmd[i] == 1) chk(lg_addr[i] == r, "R9 row address", lg_addr[i], r);
            if (ecmd[i] == 2 || ecmd[i] == 3) chk(lg_addr[i] == c, "R9 column address", lg_addr[i], c);
            if (ecmd[i] == 3) chk(lg_wd[i] == int'(d), "R8 write data", lg_wd[i], int'(d));
        end
        chk(done_c == kcol + C, "R6 ready return cycle", done_c - k, kcol + C - k);
        if (w) begin
            chk(rs_n == 0, "R8 no strobe on write", rs_n, 0);
            ref_mem[idx_of(b, r, c)] = d;
        end else begin
            exp_d = ref_mem[idx_of(b, r, c)];
            chk(rs_n == 1, "R7 single strobe", rs_n, 1);
            chk(rs_cyc == kcol + C, "R7 strobe cycle", rs_cyc - k, kcol + C - k);
            chk(rs_data == exp_d, "R7 read data", int'(rs_data), int'(exp_d));
        end
    endtask

    // {kind[1:0], write, bank[1:0], row[3:0], col[2:0], wdata[7:0]}
    localparam int NV = 13;
    localparam logic [19:0] VEC [NV] = '{
        {2'd1, 1'b0, 2'd0, 4'd3,  3'd1, 8'h00},
        {2'd0, 1'b0, 2'd0, 4'd3,  3'd5, 8'h00},
        {2'd0, 1'b1, 2'd0, 4'd3,  3'd5, 8'hA5},
        {2'd0, 1'b0, 2'd0, 4'd3,  3'd5, 8'h00},
        {2'd1, 1'b1, 2'd1, 4'd7,  3'd0, 8'h3C},
        {2'd2, 1'b0, 2'd1, 4'd2,  3'd0, 8'h00},
        {2'd2, 1'b0, 2'd1, 4'd7,  3'd0, 8'h00},
        {2'd1, 1'b0, 2'd2, 4'd0,  3'd7, 8'h00},
        {2'd1, 1'b0, 2'd3, 4'd15, 3'd2, 8'h00},
        {2'd0, 1'b1, 2'd3, 4'd15, 3'd2, 8'hFF},
        {2'd2, 1'b0, 2'd0, 4'd9,  3'd1, 8'h00},
        {2'd2, 1'b0, 2'd0, 4'd3,  3'd5, 8'h00},
        {2'd0, 1'b0, 2'd2, 4'd0,  3'd7, 8'h00}
    };

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(req_ready == 1'b1, "R1 ready during reset", int'(req_ready), 1);
        rst = 1'b0;
        @(negedge clk); #1;
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1 strobe low after reset", int'(rsp_valid), 0);
        chk(dram_cmd == 3'd0, "R1 NOP after reset", int'(dram_cmd), 0);

        for (int v = 0; v < NV; v++) begin
            do_req(int'(VEC[v][19:18]), VEC[v][17], int'(VEC[v][16:15]),
                   int'(VEC[v][14:11]), int'(VEC[v][10:8]), VEC[v][7:0]);
        end

        // R1: reset in the middle of a conflict sequence closes every bank
        req_bank = 2'd2; req_row = 4'd6; req_col = 3'd0; req_write = 1'b0;
        req_valid = 1'b1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk); #1;
        rst = 1'b1;
        @(negedge clk); #1;
        @(negedge clk); #1;
        rst = 1'b0;
        chk(req_ready == 1'b1, "R1 ready after mid-sequence reset", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1 no strobe after mid-sequence reset", int'(rsp_valid), 0);
        chk(dram_cmd == 3'd0, "R1 NOP after mid-sequence reset", int'(dram_cmd), 0);
        // Bank 0 row 3 was open before reset; it must now start with an activate
        do_req(1, 1'b0, 0, 3, 5, 8'h00);
        do_req(0, 1'b0, 0, 3, 5, 8'h00);
        do_req(2, 1'b0, 0, 4, 4, 8'h00);

        chk(proto_err == 0, "R3 device protocol (activate on open / access on closed)", proto_err, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule